// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Master Controller

This block drives a serial EEPROM of 64 sixteen-bit words over three wires plus a returned data line. The lines are chip select, serial clock, data toward the memory, and data from the memory. A host hands it one command at a time through a valid/ready pair. The command carries a 3-bit code, a 6-bit word address and, for the two write forms, a 16-bit data word. The block turns the command into a serial frame and generates the serial clock from the system clock with a divider. On reads it collects the returned word. After any program or erase it polls the memory's ready indication.

Each command completes with a one-cycle `done` pulse. A read leaves its word on `rdata`. If programming does not finish within a bounded number of system cycles, `err` is set at `done`. Between frames chip select stays low for a configurable minimum time. Outside a frame the data line toward the memory rests low.

Top module: `serprom_master`

## Requirements
- R1: Out of reset and whenever idle, `ee_cs`, `ee_sk` and `ee_di` are low and `cmd_ready` is high; `done` is low after reset.
- R2: Every frame starts with a 1 bit, then a 2-bit opcode, then a 6-bit address, all MSB first on `ee_di`, each bit taken by the memory on a rising `ee_sk`; `ee_sk` is high only while `ee_cs` is high. Command codes and opcodes: 0 read (opcode 10), 1 write (01), 2 erase (11).
- R3: Codes 3 to 6 send opcode 00 and select the action in the two top address bits, with the lower four address bits sent as 0: 3 write enable (11), 4 write disable (00), 5 erase all (10), 6 write all (01).
- R4: Write and write-all frames last 25 serial clocks, with the data word sent D15 first after the address. Read frames last 25 clocks, with `ee_di` low after the address. All other frames last 9 clocks.
- R5: On a read, the bit returned after the last address bit is discarded and the next 16 bits, sampled while `ee_sk` is high just before each falling edge, appear on `rdata` MSB first when `done` pulses.
- R6: Each high phase and each low phase of `ee_sk` inside a frame lasts exactly CLK_DIV system cycles.
- R7: `ee_cs` is low for at least CS_LOW_CYC system cycles before every rise.
- R8: After a write, erase, erase-all or write-all frame, `ee_cs` is raised again and `ee_do` is polled. The third and later polling cycles count, and `done` follows only after `ee_do` reads high.
- R9: If `ee_do` has not read high within TIMEOUT_CYC polling cycles, polling stops and `done` pulses with `err` high. Otherwise `err` is low at `done`.
- R10: `cmd_ready` is high only when idle, a command is taken when `cmd_valid` and `cmd_ready` are both high, and `done` is a single-cycle pulse seen together with `cmd_ready`.
- R11: `ee_di` does not change while `ee_sk` is high.
- R12: Command code 7 acts exactly as write disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Host offers a command |
| cmd_ready | output | 1 | Controller idle and able to take a command |
| cmd_code | input | 3 | Command code (see R2, R3, R12) |
| cmd_addr | input | 6 | Word address |
| cmd_wdata | input | 16 | Write data for write and write-all |
| rdata | output | 16 | Word returned by the last read |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Programming timeout, valid with done |
| ee_cs | output | 1 | Chip select to memory |
| ee_sk | output | 1 | Serial clock to memory |
| ee_di | output | 1 | Serial data toward memory |
| ee_do | input | 1 | Serial data and ready status from memory |

## Verification
The assertions check on every cycle the line rules that hold in any state:
- the idle levels;
- the serial clock appearing only under chip select;
- the data line holding still through every high phase;
- the exact length of each clock phase;
- the minimum chip-select low time;
- the shape of the done pulse.

Frame content, the dropped dummy bit and the returned words can only be shown by the bench scenarios. So can the effect of the write-enable latch, the wait for the memory's busy time, the timeout flag and the aliasing of code 7. The bench does this against a behavioural memory that models busy timing and the enable latch.

// File: rtl/serprom_pkg.sv
package serprom_pkg;

    localparam int FRAME_W = 25;
    localparam int HDR_W   = 9;
    localparam int WORD_W  = 16;
    localparam int ADDR_W  = 6;

    localparam logic [2:0] C_READ  = 3'd0;
    localparam logic [2:0] C_WRITE = 3'd1;
    localparam logic [2:0] C_ERASE = 3'd2;
    localparam logic [2:0] C_WREN  = 3'd3;
    localparam logic [2:0] C_WRDIS = 3'd4;
    localparam logic [2:0] C_ERALL = 3'd5;
    localparam logic [2:0] C_WRALL = 3'd6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_GAP,
        ST_POLL
    } state_e;

endpackage

// File: rtl/serprom_tick.sv
module serprom_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q, cnt_d;

    assign tick = run && (cnt_q == CW'(DIV - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/serprom_frame.sv
module serprom_frame
    import serprom_pkg::*;
(
    input  logic [2:0]         code,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [WORD_W-1:0]  wdata,
    output logic [FRAME_W-1:0] frame,
    output logic [4:0]         nbits,
    output logic               is_read,
    output logic               is_prog
);
    logic [1:0]        op;
    logic [ADDR_W-1:0] afield;
    logic              with_data;

    always_comb begin
        op        = 2'b00;
        afield    = '0;
        with_data = 1'b0;
        is_read   = 1'b0;
        is_prog   = 1'b0;
        case (code)
            C_READ:  begin op = 2'b10; afield = addr; is_read = 1'b1; end
            C_WRITE: begin op = 2'b01; afield = addr; with_data = 1'b1; is_prog = 1'b1; end
            C_ERASE: begin op = 2'b11; afield = addr; is_prog = 1'b1; end
            C_WREN:  afield = 6'b11_0000;
            C_ERALL: begin afield = 6'b10_0000; is_prog = 1'b1; end
            C_WRALL: begin afield = 6'b01_0000; with_data = 1'b1; is_prog = 1'b1; end
            default: afield = 6'b00_0000;
        endcase
        frame = {1'b1, op, afield, (with_data ? wdata : {WORD_W{1'b0}})};
        nbits = (with_data || is_read) ? 5'(FRAME_W) : 5'(HDR_W);
    end
endmodule

// File: rtl/serprom_master.sv
module serprom_master
    import serprom_pkg::*;
#(
    parameter int CLK_DIV     = 4,
    parameter int CS_LOW_CYC  = 113,
    parameter int TIMEOUT_CYC = 2_500_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_code,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [WORD_W-1:0] cmd_wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              done,
    output logic              err,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);
    localparam int GW = $clog2(CS_LOW_CYC + 1);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);

    typedef struct packed {
        state_e             st;
        logic [FRAME_W-1:0] frame;
        logic [4:0]         left;
        logic               cs;
        logic               sk;
        logic               di;
        logic [WORD_W-1:0]  rx;
        logic [WORD_W-1:0]  rdata;
        logic               rd;
        logic               prog;
        logic               polled;
        logic               done;
        logic               err;
        logic [GW-1:0]      gap;
        logic [TW-1:0]      wait_cnt;
    } regs_t;

    regs_t r_q, r_d;

    logic               tick;
    logic [FRAME_W-1:0] f_frame;
    logic [4:0]         f_nbits;
    logic               f_read, f_prog;

    serprom_tick #(.DIV(CLK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (r_q.st == ST_SHIFT),
        .tick  (tick)
    );

    serprom_frame u_frame (
        .code    (cmd_code),
        .addr    (cmd_addr),
        .wdata   (cmd_wdata),
        .frame   (f_frame),
        .nbits   (f_nbits),
        .is_read (f_read),
        .is_prog (f_prog)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    r_d.st     = ST_SHIFT;
                    r_d.frame  = f_frame;
                    r_d.left   = f_nbits;
                    r_d.rd     = f_read;
                    r_d.prog   = f_prog;
                    r_d.polled = 1'b0;
                    r_d.err    = 1'b0;
                    r_d.cs     = 1'b1;
                    r_d.sk     = 1'b0;
                    r_d.di     = f_frame[FRAME_W-1];
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (!r_q.sk) begin
                        r_d.sk = 1'b1;
                    end else begin
                        r_d.sk = 1'b0;
                        r_d.rx = {r_q.rx[WORD_W-2:0], ee_do};
                        if (r_q.left == 5'd1) begin
                            r_d.st  = ST_GAP;
                            r_d.cs  = 1'b0;
                            r_d.di  = 1'b0;
                            r_d.gap = '0;
                            if (r_q.rd) r_d.rdata = {r_q.rx[WORD_W-2:0], ee_do};
                        end else begin
                            r_d.left  = r_q.left - 5'd1;
                            r_d.frame = {r_q.frame[FRAME_W-2:0], 1'b0};
                            r_d.di    = r_q.frame[FRAME_W-2];
                        end
                    end
                end
            end
            ST_GAP: begin
                r_d.gap = r_q.gap + 1'b1;
                if (r_q.gap == GW'(CS_LOW_CYC - 1)) begin
                    if (r_q.prog && !r_q.polled) begin
                        r_d.st       = ST_POLL;
                        r_d.cs       = 1'b1;
                        r_d.wait_cnt = '0;
                    end else begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end
                end
            end
            ST_POLL: begin
                r_d.wait_cnt = r_q.wait_cnt + 1'b1;
                if ((r_q.wait_cnt >= TW'(2)) && ee_do) begin
                    r_d.polled = 1'b1;
                    r_d.cs     = 1'b0;
                    r_d.st     = ST_GAP;
                    r_d.gap    = '0;
                end else if (r_q.wait_cnt == TW'(TIMEOUT_CYC - 1)) begin
                    r_d.polled = 1'b1;
                    r_d.err    = 1'b1;
                    r_d.cs     = 1'b0;
                    r_d.st     = ST_GAP;
                    r_d.gap    = '0;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_ready = (r_q.st == ST_IDLE);
    assign rdata     = r_q.rdata;
    assign done      = r_q.done;
    assign err       = r_q.err;
    assign ee_cs     = r_q.cs;
    assign ee_sk     = r_q.sk;
    assign ee_di     = r_q.di;
endmodule

// File: rtl/serprom_master_chk.sv
module serprom_master_chk #(
    parameter int CLK_DIV    = 4,
    parameter int CS_LOW_CYC = 113
) (
    input logic clk,
    input logic rst_n,
    input logic cmd_ready,
    input logic done,
    input logic cs,
    input logic sk,
    input logic di
);
    localparam int HW = $clog2(CLK_DIV + 2) + 1;
    localparam int LW = $clog2(CS_LOW_CYC + 2) + 1;

    logic          sk_prev, cs_prev;
    logic [HW-1:0] hold;
    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sk_prev <= 1'b0;
            cs_prev <= 1'b0;
            hold    <= '0;
            low_cnt <= LW'(CS_LOW_CYC);
        end else begin
            sk_prev <= sk;
            cs_prev <= cs;
            if (sk != sk_prev)                hold <= HW'(1);
            else if (hold != {HW{1'b1}})      hold <= hold + 1'b1;
            if (cs)                           low_cnt <= '0;
            else if (low_cnt != {LW{1'b1}})   low_cnt <= low_cnt + 1'b1;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!cs && !sk && !di)); // R1
    AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        sk |-> cs); // R2
    AST_DI_HELD_SK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sk && $past(sk)) |-> $stable(di)); // R11
    AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (sk_prev && !sk) |-> (hold == HW'(CLK_DIV))); // R6
    AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && !cs_prev) |-> (low_cnt >= LW'(CS_LOW_CYC))); // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_DONE_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_ready); // R10
endmodule

bind serprom_master serprom_master_chk #(
    .CLK_DIV    (CLK_DIV),
    .CS_LOW_CYC (CS_LOW_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_ready (cmd_ready),
    .done      (done),
    .cs        (ee_cs),
    .sk        (ee_sk),
    .di        (ee_di)
);

// File: tb/serprom_master_tb.sv
`timescale 1ns/1ps
module serprom_master_tb;
    localparam int CLK_DIV  = 2;
    localparam int CS_LOW   = 5;
    localparam int TMO      = 400;
    localparam int BUSY_CYC = 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_code = '0;
    logic [5:0]  cmd_addr = '0;
    logic [15:0] cmd_wdata = '0;
    logic [15:0] rdata;
    logic        done, err, ee_cs, ee_sk, ee_di;
    logic        ee_do = 1'b1;

    always #2 clk = ~clk;

    serprom_master #(.CLK_DIV(CLK_DIV), .CS_LOW_CYC(CS_LOW), .TIMEOUT_CYC(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rdata(rdata), .done(done), .err(err),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do));

    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural memory model
    logic [15:0] mem [64];
    bit          wen = 0;
    bit          stuck = 0;
    int          busy = 0;
    int          mbits = 0;
    logic [24:0] msh = '0;
    logic [1:0]  mop = '0;
    logic [5:0]  maddr = '0;
    logic [15:0] mrd = '0;
    logic        m_cs_p = 0, m_sk_p = 0;

    // monitor state
    logic [24:0] cap = '0;
    int          ncap = 0;
    int          ph_len = 0, ph_bad = 0;
    int          lo_len = 1000, gap_bad = 0;
    int          di_bad = 0;
    logic        mon_sk_p = 0, mon_di_p = 0, mon_cs_p = 0;

    always @(negedge clk) begin
        if (busy > 0 && !stuck) busy--;
        if (ee_cs && !m_cs_p) begin mbits = 0; msh = '0; end
        if (ee_cs && ee_sk && !m_sk_p) begin
            mbits++;
            msh = {msh[23:0], ee_di};
            if (mbits == 9) begin mop = msh[7:6]; maddr = msh[5:0]; mrd = mem[msh[5:0]]; end
        end
        if (!ee_cs && m_cs_p) begin
            if (mbits == 9 || mbits == 25) begin
                case (mop)
                    2'b01: if (wen && mbits == 25) begin mem[maddr] = msh[15:0]; busy = BUSY_CYC; end
                    2'b11: if (wen) begin mem[maddr] = 16'hFFFF; busy = BUSY_CYC; end
                    2'b00: case (maddr[5:4])
                        2'b11: wen = 1;
                        2'b00: wen = 0;
                        2'b10: if (wen) begin
                            for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
                            busy = BUSY_CYC;
                        end
                        default: if (wen && mbits == 25) begin
                            for (int i = 0; i < 64; i++) mem[i] = msh[15:0];
                            busy = BUSY_CYC;
                        end
                    endcase
                    default: ;
                endcase
            end
            mbits = 0;
        end
        if (ee_cs && mop == 2'b10 && mbits >= 9 && mbits <= 25)
            ee_do = (mbits == 9) ? 1'b0 : mrd[15 - (mbits - 10)];
        else if (ee_cs && mbits == 0)
            ee_do = (busy == 0);
        else
            ee_do = 1'b1;
        if (ee_cs && mbits == 0 && !m_cs_p) mop = 2'b00;
        m_cs_p = ee_cs;
        m_sk_p = ee_sk;

        // per-cycle line monitor
        if (rst_n) begin
            if (ee_sk && !mon_sk_p) begin cap = {cap[23:0], ee_di}; ncap++; end
            if (ee_sk && mon_sk_p && ee_di !== mon_di_p) di_bad++;       // R11
            if (ee_sk !== mon_sk_p) begin
                if (mon_sk_p && ph_len != CLK_DIV) ph_bad++;           // R6
                ph_len = 1;
            end else ph_len++;
            if (ee_cs && !mon_cs_p && lo_len < CS_LOW) gap_bad++;     // R7
            if (ee_cs) lo_len = 0; else lo_len++;
            if (ee_sk && !ee_cs) ph_bad++;                             // R2
        end
        mon_sk_p = ee_sk; mon_di_p = ee_di; mon_cs_p = ee_cs;
    end

    function automatic logic [24:0] exp_frame(input logic [2:0] c, input logic [5:0] a, input logic [15:0] d);
        logic [8:0] h;
        case (c)
            3'd0: h = {3'b110, a};
            3'd1: h = {3'b101, a};
            3'd2: h = {3'b111, a};
            3'd3: h = 9'b100_110000;
            3'd5: h = 9'b100_100000;
            3'd6: h = 9'b100_010000;
            default: h = 9'b100_000000;
        endcase
        return {h, (c == 3'd1 || c == 3'd6) ? d : 16'h0};
    endfunction

    logic [15:0] got_rd;
    logic        got_err;

    task automatic issue(input logic [2:0] c, input logic [5:0] a, input logic [15:0] d, input string req);
        int n;
        logic [24:0] ef;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cap = '0; ncap = 0;
        cmd_code = c; cmd_addr = a; cmd_wdata = d; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(!cmd_ready, "R10 ready low after accept", cmd_ready, 0);
        while (!done) @(negedge clk);
        got_rd = rdata; got_err = err;
        n  = (c == 3'd0 || c == 3'd1 || c == 3'd6) ? 25 : 9;
        ef = exp_frame(c, a, d);
        check(ncap == n, {req, " R4 clock count"}, ncap, n);
        if (n == 25) check(cap == ef, {req, " R2 R3 R4 frame bits"}, cap, ef);
        else         check(cap[8:0] == ef[24:16], {req, " R2 R3 frame bits"}, cap[8:0], ef[24:16]);
        @(negedge clk);
        check(!done, "R10 done one cycle", done, 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'(i * 977 + 3);
        repeat (3) @(negedge clk);
        check(!ee_cs && !ee_sk && !ee_di && cmd_ready && !done, "R1 reset state",
              {ee_cs, ee_sk, ee_di, cmd_ready, done}, 5'b00010);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!ee_cs && !ee_sk && !ee_di && cmd_ready, "R1 idle lines", {ee_cs, ee_sk, ee_di, cmd_ready}, 4'b0001);

        issue(3'd0, 6'd17, 16'h0, "read");
        check(got_rd == 16'(17 * 977 + 3), "R5 read initial word", got_rd, 16'(17 * 977 + 3));

        issue(3'd3, 6'd0, 16'h0, "wren");
        issue(3'd1, 6'd5, 16'hA5C3, "write");
        check(got_err == 0, "R9 no error on normal write", got_err, 0);
        check(busy == 0, "R8 done only after memory ready", busy, 0);
        issue(3'd0, 6'd5, 16'h0, "read");
        check(got_rd == 16'hA5C3, "R5 read written word", got_rd, 16'hA5C3);

        issue(3'd4, 6'd0, 16'h0, "wrdis");
        issue(3'd1, 6'd5, 16'h1111, "write disabled");
        issue(3'd0, 6'd5, 16'h0, "read");
        check(got_rd == 16'hA5C3, "R3 write disable blocks write", got_rd, 16'hA5C3);

        issue(3'd3, 6'd0, 16'h0, "wren");
        issue(3'd7, 6'd0, 16'h0, "code7");
        issue(3'd1, 6'd6, 16'h2222, "write after code7");
        issue(3'd0, 6'd6, 16'h0, "read");
        check(got_rd == 16'(6 * 977 + 3), "R12 code 7 disables writes", got_rd, 16'(6 * 977 + 3));

        issue(3'd3, 6'd0, 16'h0, "wren");
        issue(3'd6, 6'd0, 16'hBEEF, "wrall");
        check(busy == 0, "R8 wrall waits ready", busy, 0);
        issue(3'd0, 6'd0, 16'h0, "read");
        check(got_rd == 16'hBEEF, "R3 write-all word 0", got_rd, 16'hBEEF);
        issue(3'd0, 6'd63, 16'h0, "read");
        check(got_rd == 16'hBEEF, "R3 write-all word 63", got_rd, 16'hBEEF);

        issue(3'd2, 6'd63, 16'h0, "erase");
        issue(3'd0, 6'd63, 16'h0, "read");
        check(got_rd == 16'hFFFF, "R2 erase word", got_rd, 16'hFFFF);
        issue(3'd0, 6'd62, 16'h0, "read");
        check(got_rd == 16'hBEEF, "R2 erase touches one word", got_rd, 16'hBEEF);

        issue(3'd1, 6'd9, 16'h0F0F, "write");
        issue(3'd5, 6'd0, 16'h0, "erall");
        issue(3'd0, 6'd9, 16'h0, "read");
        check(got_rd == 16'hFFFF, "R3 erase all", got_rd, 16'hFFFF);

        stuck = 1;
        issue(3'd1, 6'd1, 16'h1234, "write stuck");
        check(got_err == 1, "R9 timeout flag", got_err, 1);
        stuck = 0; busy = 0;
        issue(3'd1, 6'd2, 16'h4321, "write");
        check(got_err == 0, "R9 flag clears", got_err, 0);
        issue(3'd0, 6'd2, 16'h0, "read");
        check(got_rd == 16'h4321, "R5 read after recovery", got_rd, 16'h4321);

        check(ph_bad == 0, "R6 clock phase lengths", ph_bad, 0);
        check(gap_bad == 0, "R7 chip select low time", gap_bad, 0);
        check(di_bad == 0, "R11 data stable while clock high", di_bad, 0);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule